// File: doc/BRIEF.md
# Sync and Blanking Pin Multiplexer

This block drives two shared video pins from the horizontal and vertical blanking and sync signals of a display timing generator. A mode input selects one of two arrangements. In composite mode the blank pin carries composite blanking and the sync pin carries composite sync. In separate mode the blank pin carries vertical blanking only and the sync pin carries horizontal blanking.

In composite mode a direction input decides whether the block drives the sync pin or leaves it for an external composite sync source. When the block drives the pin, the composite sync is built from one of two pairs of active-low horizontal and vertical syncs: the internal timer pair or an external pair. When the pin is an input, its level passes through a synchronizer and appears on `csync_rx_o` for the sync-recovery logic that follows.

All pin outputs come from registers. A change on any input, mode and selects included, shows on the outputs at the first rising clock edge after the change. Reset sets the pins to the composite defaults: the blank pin drives an inactive composite blanking level, and the sync pin is an input.

Top module: `sync_blank_mux`

## Requirements
- R1: While rst_ni is low, blank_pin_o=1, sync_pin_o=1, sync_pin_oe_o=0 and csync_rx_o=1. These are composite mode with the sync pin set as an input.
- R2: Composite mode (sep_mode_i=0): after the next rising edge, blank_pin_o is low exactly when hblank_i or vblank_i was high.
- R3: Separate mode (sep_mode_i=1): after the next rising edge, blank_pin_o is the inverse of vblank_i, and hblank_i has no effect on it.
- R4: Separate mode: after the next rising edge, sync_pin_o is the inverse of hblank_i and sync_pin_oe_o=1, whatever csync_drive_i is.
- R5: Composite mode with csync_drive_i=1: sync_pin_oe_o=1, and sync_pin_o is low when either the selected horizontal sync or the selected vertical sync is low.
- R6: sync_src_int_i=1 selects tmr_hsync_ni/tmr_vsync_ni and sync_src_int_i=0 selects ext_hsync_ni/ext_vsync_ni. The pair not selected has no effect on sync_pin_o.
- R7: Composite mode with csync_drive_i=0: after the next rising edge, sync_pin_oe_o=0 and sync_pin_o=1.
- R8: csync_rx_o follows csync_pad_i through RX_STAGES flops when composite input direction is selected. In every other setting it is held at 1.
- R9: A mode, direction or source change shows on the outputs at the first rising edge after it, not earlier. This also applies when the change falls in the same cycle as a blanking change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sep_mode_i | input | 1 | 0 composite mode, 1 separate mode |
| csync_drive_i | input | 1 | Composite mode: 1 drives the sync pin, 0 makes it an input |
| sync_src_int_i | input | 1 | 1 uses the internal timer syncs, 0 the external syncs |
| tmr_hsync_ni | input | 1 | Internal horizontal sync, active low |
| tmr_vsync_ni | input | 1 | Internal vertical sync, active low |
| ext_hsync_ni | input | 1 | External horizontal sync, active low |
| ext_vsync_ni | input | 1 | External vertical sync, active low |
| hblank_i | input | 1 | Horizontal blanking interval, active high |
| vblank_i | input | 1 | Vertical blanking interval, active high |
| csync_pad_i | input | 1 | Level received from the sync pin |
| blank_pin_o | output | 1 | Blank pin level, active low |
| sync_pin_o | output | 1 | Sync pin level driven when enabled |
| sync_pin_oe_o | output | 1 | Output enable for the sync pin |
| csync_rx_o | output | 1 | Synchronized composite sync received from the pin |

## Verification
The mode or direction select can change in the same cycle as the blanking and sync inputs, and the sync pin must then switch function at the same edge where the new levels appear. The vector table changes mode, direction and source on almost every row while the blanking and sync levels also change. Each row is checked one edge later against the level the new mode calls for. One directed case also samples before the edge to confirm that the old output is still held.

// File: rtl/vsm_pkg.sv
package vsm_pkg;
  typedef enum logic {
    VMODE_COMP = 1'b0,
    VMODE_SEP  = 1'b1
  } vmode_e;
endpackage

// File: rtl/vsm_csync_gen.sv
// Active-low composite sync from one of two active-low sync pairs.
module vsm_csync_gen (
  input  logic sel_int_i,
  input  logic int_hs_ni,
  input  logic int_vs_ni,
  input  logic ext_hs_ni,
  input  logic ext_vs_ni,
  output logic csync_no
);
  logic hs_n, vs_n;
  always_comb begin
    hs_n     = sel_int_i ? int_hs_ni : ext_hs_ni;
    vs_n     = sel_int_i ? int_vs_ni : ext_vs_ni;
    csync_no = hs_n & vs_n;
  end
endmodule

// File: rtl/vsm_blank_mux.sv
module vsm_blank_mux
  import vsm_pkg::*;
(
  input  vmode_e mode_i,
  input  logic   hblank_i,
  input  logic   vblank_i,
  output logic   blank_pin_no,
  output logic   hblank_pin_no
);
  always_comb begin
    unique case (mode_i)
      VMODE_SEP:  blank_pin_no = ~vblank_i;
      default:    blank_pin_no = ~(hblank_i | vblank_i);
    endcase
    hblank_pin_no = ~hblank_i;
  end
endmodule

// File: rtl/vsm_rx_sync.sv
module vsm_rx_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) chain_q[0] <= 1'b1;
    else         chain_q[0] <= d_i;
  end

  for (genvar s = 1; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) chain_q[s] <= 1'b1;
      else         chain_q[s] <= chain_q[s-1];
    end
  end

  assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/sync_blank_mux.sv
module sync_blank_mux
  import vsm_pkg::*;
#(
  parameter int unsigned RX_STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic sep_mode_i,
  input  logic csync_drive_i,
  input  logic sync_src_int_i,
  input  logic tmr_hsync_ni,
  input  logic tmr_vsync_ni,
  input  logic ext_hsync_ni,
  input  logic ext_vsync_ni,
  input  logic hblank_i,
  input  logic vblank_i,
  input  logic csync_pad_i,
  output logic blank_pin_o,
  output logic sync_pin_o,
  output logic sync_pin_oe_o,
  output logic csync_rx_o
);
  localparam int unsigned RxDepth = (RX_STAGES < 1) ? 1 : RX_STAGES;

  vmode_e mode_w;
  logic   csync_n_w, blank_n_w, hblank_n_w, rx_w;
  logic   sync_d, oe_d, rx_mode_d;
  logic   blank_q, sync_q, oe_q, rx_mode_q;

  assign mode_w = sep_mode_i ? VMODE_SEP : VMODE_COMP;

  vsm_csync_gen i_csync_gen (
    .sel_int_i (sync_src_int_i),
    .int_hs_ni (tmr_hsync_ni),
    .int_vs_ni (tmr_vsync_ni),
    .ext_hs_ni (ext_hsync_ni),
    .ext_vs_ni (ext_vsync_ni),
    .csync_no  (csync_n_w)
  );

  vsm_blank_mux i_blank_mux (
    .mode_i        (mode_w),
    .hblank_i      (hblank_i),
    .vblank_i      (vblank_i),
    .blank_pin_no  (blank_n_w),
    .hblank_pin_no (hblank_n_w)
  );

  vsm_rx_sync #(.STAGES(RxDepth)) i_rx_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    (csync_pad_i),
    .q_o    (rx_w)
  );

  always_comb begin
    rx_mode_d = 1'b0;
    unique case (mode_w)
      VMODE_SEP: begin
        oe_d   = 1'b1;
        sync_d = hblank_n_w;
      end
      default: begin
        oe_d      = csync_drive_i;
        sync_d    = csync_drive_i ? csync_n_w : 1'b1;  // idle high when released
        rx_mode_d = ~csync_drive_i;
      end
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      blank_q   <= 1'b1;
      sync_q    <= 1'b1;
      oe_q      <= 1'b0;
      rx_mode_q <= 1'b1;
    end else begin
      blank_q   <= blank_n_w;
      sync_q    <= sync_d;
      oe_q      <= oe_d;
      rx_mode_q <= rx_mode_d;
    end
  end

  assign blank_pin_o   = blank_q;
  assign sync_pin_o    = sync_q;
  assign sync_pin_oe_o = oe_q;
  assign csync_rx_o    = rx_w | ~rx_mode_q;
endmodule

// File: rtl/sync_blank_mux_chk.sv
module sync_blank_mux_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic sep_mode_i,
  input logic csync_drive_i,
  input logic sync_src_int_i,
  input logic tmr_hsync_ni,
  input logic tmr_vsync_ni,
  input logic ext_hsync_ni,
  input logic ext_vsync_ni,
  input logic hblank_i,
  input logic vblank_i,
  input logic csync_pad_i,
  input logic blank_pin_o,
  input logic sync_pin_o,
  input logic sync_pin_oe_o,
  input logic csync_rx_o
);
  logic armed_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) armed_q <= 1'b0;
    else         armed_q <= 1'b1;
  end

  always @(negedge clk_i) begin
    if (!rst_ni) begin
      p_reset_pins_r1: assert (blank_pin_o && sync_pin_o && !sync_pin_oe_o && csync_rx_o);
    end
  end

  p_comp_blank_r2: assert property (@(posedge clk_i) disable iff (!rst_ni || !armed_q)
    $past(!sep_mode_i) |-> (blank_pin_o == !$past(hblank_i || vblank_i)));

  p_sep_vblank_r3: assert property (@(posedge clk_i) disable iff (!rst_ni || !armed_q)
    $past(sep_mode_i) |-> (blank_pin_o == !$past(vblank_i)));

  p_sep_hblank_r4: assert property (@(posedge clk_i) disable iff (!rst_ni || !armed_q)
    $past(sep_mode_i) |-> (sync_pin_oe_o && (sync_pin_o == !$past(hblank_i))));

  p_comp_csync_r5: assert property (@(posedge clk_i) disable iff (!rst_ni || !armed_q)
    $past(!sep_mode_i && csync_drive_i && sync_src_int_i)
      |-> (sync_pin_oe_o && (sync_pin_o == $past(tmr_hsync_ni && tmr_vsync_ni))));

  p_ext_src_r6: assert property (@(posedge clk_i) disable iff (!rst_ni || !armed_q)
    $past(!sep_mode_i && csync_drive_i && !sync_src_int_i)
      |-> (sync_pin_o == $past(ext_hsync_ni && ext_vsync_ni)));

  p_released_r7: assert property (@(posedge clk_i) disable iff (!rst_ni || !armed_q)
    $past(!sep_mode_i && !csync_drive_i) |-> (!sync_pin_oe_o && sync_pin_o));

  p_rx_idle_r8: assert property (@(posedge clk_i) disable iff (!rst_ni || !armed_q)
    $past(sep_mode_i || csync_drive_i) |-> csync_rx_o);
endmodule

bind sync_blank_mux sync_blank_mux_chk i_sync_blank_mux_chk (.*);

// File: tb/test_sync_blank_mux.sv
`timescale 1ns/1ps
module test_sync_blank_mux;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sep, drv, src_int, ths, tvs, ehs, evs, hb, vb, pad;
  logic blank, sync, oe, rx;
  int   n_chk = 0;
  int   n_err = 0;

  always #5 clk = ~clk;

  sync_blank_mux #(.RX_STAGES(2)) i_sync_blank_mux (
    .clk_i(clk), .rst_ni(rst_n), .sep_mode_i(sep), .csync_drive_i(drv),
    .sync_src_int_i(src_int), .tmr_hsync_ni(ths), .tmr_vsync_ni(tvs),
    .ext_hsync_ni(ehs), .ext_vsync_ni(evs), .hblank_i(hb), .vblank_i(vb),
    .csync_pad_i(pad), .blank_pin_o(blank), .sync_pin_o(sync),
    .sync_pin_oe_o(oe), .csync_rx_o(rx)
  );

  // {sep,drv,int,ths,tvs,ehs,evs,hb,vb, exp_blank,exp_sync,exp_oe}
  localparam int NV = 12;
  localparam logic [11:0] VEC [NV] = '{
    12'b0_1_0_1_1_0_1_0_0_1_0_1,
    12'b0_1_0_0_0_1_1_1_0_0_1_1,
    12'b0_1_1_0_1_1_1_0_1_0_0_1,
    12'b0_1_1_1_1_0_0_0_0_1_1_1,
    12'b0_1_1_1_0_1_1_1_1_0_0_1,
    12'b0_0_0_1_1_0_0_0_0_1_1_0,
    12'b0_0_1_0_0_1_1_1_0_0_1_0,
    12'b1_0_0_1_1_1_1_1_0_1_0_1,
    12'b1_1_0_0_0_0_0_0_1_0_1_1,
    12'b1_0_1_1_1_1_1_1_1_0_0_1,
    12'b1_1_1_0_0_0_0_0_0_1_1_1,
    12'b0_1_0_1_1_1_0_0_0_1_0_1
  };

  task automatic check(input string req, input logic act, input logic exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual=%b expected=%b", req, act, exp);
    end
  endtask

  task automatic apply(input logic [8:0] v);
    {sep, drv, src_int, ths, tvs, ehs, evs, hb, vb} = v;
  endtask

  initial begin
    #200000;
    n_err++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    apply(9'b0_1_1_1_1_1_1_1_1);
    pad = 1'b0;
    repeat (3) @(posedge clk);
    #1;
    // R1 reset defaults despite active inputs
    check("R1 blank", blank, 1'b1);
    check("R1 sync", sync, 1'b1);
    check("R1 oe", oe, 1'b0);
    check("R1 rx", rx, 1'b1);
    @(negedge clk) rst_n = 1'b1;

    // table: mode/dir/source change with blanking change in the same cycle (R2-R7, R9)
    for (int i = 0; i < NV; i++) begin
      @(negedge clk) apply(VEC[i][11:3]);
      @(posedge clk) #1;
      check(VEC[i][11] ? "R3/R9 blank" : "R2/R9 blank", blank, VEC[i][2]);
      check(VEC[i][11] ? "R4 sync" : (VEC[i][10] ? "R5/R6 sync" : "R7 sync"), sync, VEC[i][1]);
      check(VEC[i][11] ? "R4 oe" : (VEC[i][10] ? "R5 oe" : "R7 oe"), oe, VEC[i][0]);
    end

    // R9: old value held until the edge
    @(negedge clk) apply(9'b0_1_0_1_1_1_1_0_0);
    @(posedge clk) #1;
    check("R9 setup blank", blank, 1'b1);
    @(negedge clk) apply(9'b1_0_0_1_1_1_1_1_1);
    #1;
    check("R9 before edge blank", blank, 1'b1);
    check("R9 before edge sync", sync, 1'b1);
    @(posedge clk) #1;
    check("R9 after edge blank", blank, 1'b0);
    check("R9 after edge sync", sync, 1'b0);

    // R8: received sync path
    @(negedge clk) begin apply(9'b0_0_0_1_1_1_1_0_0); pad = 1'b0; end
    repeat (4) @(posedge clk);
    #1 check("R8 rx low", rx, 1'b0);
    @(negedge clk) pad = 1'b1;
    repeat (4) @(posedge clk);
    #1 check("R8 rx high", rx, 1'b1);
    @(negedge clk) begin apply(9'b1_0_0_1_1_1_1_0_0); pad = 1'b0; end
    repeat (4) @(posedge clk);
    #1 check("R8 rx held in separate", rx, 1'b1);
    @(negedge clk) apply(9'b0_1_0_1_1_1_1_0_0);
    repeat (4) @(posedge clk);
    #1 check("R8 rx held when driving", rx, 1'b1);

    // R1 asynchronous reset mid-run
    @(negedge clk) begin apply(9'b1_1_0_1_1_1_1_1_1); end
    @(posedge clk) #1;
    check("R1 pre blank", blank, 1'b0);
    #2 rst_n = 1'b0;
    #1;
    check("R1 async blank", blank, 1'b1);
    check("R1 async oe", oe, 1'b0);
    check("R1 async sync", sync, 1'b1);
    @(negedge clk) rst_n = 1'b1;
    repeat (2) @(posedge clk);

    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule